// File: doc/BRIEF.md
# Emulation Memory Mapper With Block Personalities

This block sits between an emulated processor's bus and the two memory spaces an in-circuit emulator can serve: the target board's own memory and the emulator's internal emulation memory. The processor address space is cut into 16KB blocks. A small mapping table, written from a host configuration port, holds one entry per block. Each entry gives a physical block number and a handful of personality bits. Those bits decide where the access goes and whether a write is illegal. They also decide whether the block keeps a record of which lines have been touched.

Each bus access is captured in one cycle while the block holds the processor with a wait request. The registered lookup result then drives the steering outputs in the next cycle. A write into a block marked as emulated ROM raises a ROM violation. Two host control bits can separately turn that violation into a stop request and a trace trigger. A write into a write-protected block raises its own violation, whether the block is mapped to target or to emulation memory. Blocks with coverage enabled set a sticky bit per 64-byte line. The host can read these bits back and clear them all with one command. Consecutive table entries may point at consecutive emulation blocks, which forms one larger contiguous emulation region.

Top module: `emu_mapper`

## Requirements
- R1: An access presented with bus_valid while no result is pending is captured at the next clock edge, and bus_wait is high during that capture cycle. In the following cycle out_valid is high, bus_wait is low, and no new capture takes place. Each access therefore takes two cycles.
- R2: The table index is the IDX_W address bits directly above the 14-bit block offset. Address bits above the index are ignored, so those blocks alias. The target address is {phys block (18 bits), offset}, and the offset passes through unchanged to both address outputs.
- R3: Entry layout on host_wdata: [17:0] phys block, [18] emulation select, [19] emulated ROM, [20] write protect, [21] coverage enable. With bit 18 set the access raises to_emu, and emu_addr = {phys[5:0], offset}, so at most 64 blocks fill the 1MB emulation memory. Otherwise it raises to_tgt. Exactly one of the two is high while out_valid is high, and neither is high otherwise. Entries with consecutive phys values give a contiguous emulation region.
- R4: rom_viol is high in the result cycle of a write to a block with bit 19 set. Reads of such a block raise no violation.
- R5: host_op 2 writes the control bits: host_wdata[0] enables stop_req and host_wdata[1] enables trace_trig. Each of these outputs follows rom_viol only when its own enable bit is set.
- R6: wp_viol is high in the result cycle of any write to a block with bit 20 set, for both target and emulation blocks. Reads raise no violation.
- R7: A read or a write to a block with bit 21 set sets the sticky coverage bit for line offset[13:6] of that table entry. The bit becomes visible one cycle after the result cycle. host_cov_rdata bit j shows line host_cov_word*32+j of entry host_cov_blk.
- R8: host_op 3 clears every coverage bit. A coverage set in the same cycle as the clear survives it.
- R9: After reset, entry i maps to target phys block i with all attributes clear, both control bits are clear, all coverage bits are clear and out_valid is low.
- R10: host_op 1 writes host_wdata into entry host_idx, and lookups captured after that clock edge use it. Host operations never raise a violation or out_valid. An emulated ROM entry stays rewritable from the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Processor access request, held while bus_wait is high |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (dominates bus_rd) |
| bus_addr | input | ADDR_W | Processor byte address |
| bus_wait | output | 1 | Wait request during the lookup cycle |
| host_op | input | 2 | 0 idle, 1 write entry, 2 write control, 3 clear coverage |
| host_idx | input | IDX_W | Entry written by host_op 1 |
| host_wdata | input | 22 | Entry value or control bits |
| host_cov_blk | input | IDX_W | Entry whose coverage is read |
| host_cov_word | input | WSEL_W | 32-line word of coverage read |
| host_cov_rdata | output | RD_W | Coverage readback |
| out_valid | output | 1 | Result cycle of an access |
| out_rd | output | 1 | Steered read |
| out_wr | output | 1 | Steered write |
| to_emu | output | 1 | Access goes to emulation memory |
| to_tgt | output | 1 | Access goes to target memory |
| emu_addr | output | 20 | Emulation memory address |
| tgt_addr | output | 32 | Target memory address |
| rom_viol | output | 1 | Write to an emulated ROM block |
| wp_viol | output | 1 | Write to a write-protected block |
| stop_req | output | 1 | Execution stop request |
| trace_trig | output | 1 | Trace trigger |

## Verification
The bench builds the block with its defaults: a 32-bit address, 16KB blocks, an 8-entry table, 64-byte coverage lines and 32-bit readback words. With only 8 entries, a single test can reach aliasing through the ignored upper address bits, a contiguous pair of emulation blocks, and both the first and the last line of a block's coverage. Because the full 18-bit phys field reaches tgt_addr, a high phys value shows whether any bit is dropped. The clear-with-concurrent-set corner is driven in the exact result cycle of an access.

// File: rtl/emu_map_pkg.sv
package emu_map_pkg;
    localparam int PHYS_W  = 18;
    localparam int ENTRY_W = PHYS_W + 4;

    typedef struct packed {
        logic              cov;
        logic              wprot;
        logic              rom;
        logic              emu;
        logic [PHYS_W-1:0] phys;
    } map_entry_t;

    typedef enum logic [1:0] {
        HOP_IDLE = 2'd0,
        HOP_MAP  = 2'd1,
        HOP_CTRL = 2'd2,
        HOP_CLR  = 2'd3
    } host_op_e;
endpackage

// File: rtl/emu_map_table.sv
module emu_map_table
    import emu_map_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  map_entry_t       wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output map_entry_t       rd_ent
);
    localparam int NENT = 1 << IDX_W;

    map_entry_t tbl_d [NENT];
    map_entry_t tbl_q [NENT];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                tbl_q[i] <= '{cov: 1'b0, wprot: 1'b0, rom: 1'b0, emu: 1'b0,
                              phys: PHYS_W'(i)};
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ent = tbl_q[rd_idx];
endmodule

// File: rtl/emu_cov_store.sv
module emu_cov_store #(
    parameter int IDX_W  = 3,
    parameter int LINE_N = 256,
    parameter int RD_W   = 32,
    localparam int LSEL_W = $clog2(LINE_N),
    localparam int NWORD  = LINE_N / RD_W,
    localparam int WSEL_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_blk,
    input  logic [LSEL_W-1:0] set_line,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_blk,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [RD_W-1:0]   rd_data
);
    localparam int NBLK = 1 << IDX_W;

    logic [LINE_N-1:0] cov_d [NBLK];
    logic [LINE_N-1:0] cov_q [NBLK];

    always_comb begin
        cov_d = cov_q;
        if (clr) begin
            for (int b = 0; b < NBLK; b++) begin
                cov_d[b] = '0;
            end
        end
        if (set_en) begin
            cov_d[set_blk][set_line] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                cov_q[b] <= '0;
            end
        end else begin
            cov_q <= cov_d;
        end
    end

    assign rd_data = cov_q[rd_blk][rd_word*RD_W +: RD_W];
endmodule

// File: rtl/emu_access_stage.sv
module emu_access_stage
    import emu_map_pkg::*;
#(
    parameter int BLK_W = 14,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [BLK_W-1:0] in_off,
    input  logic [IDX_W-1:0] in_idx,
    input  map_entry_t       in_ent,
    input  logic             ctl_we,
    input  logic [1:0]       ctl_bits,
    output logic             capture,
    output logic             st_vld,
    output logic             st_rd,
    output logic             st_wr,
    output logic [BLK_W-1:0] st_off,
    output logic [IDX_W-1:0] st_idx,
    output map_entry_t       st_ent,
    output logic             stop_en,
    output logic             trace_en
);
    typedef struct packed {
        logic             vld;
        logic             rd;
        logic             wr;
        logic [BLK_W-1:0] off;
        logic [IDX_W-1:0] idx;
        map_entry_t       ent;
        logic             stop_en;
        logic             trace_en;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        capture  = bus_valid && !st_q.vld;
        st_d.vld = capture;
        if (capture) begin
            st_d.wr  = bus_wr;
            st_d.rd  = bus_rd && !bus_wr;
            st_d.off = in_off;
            st_d.idx = in_idx;
            st_d.ent = in_ent;
        end
        if (ctl_we) begin
            st_d.stop_en  = ctl_bits[0];
            st_d.trace_en = ctl_bits[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_vld   = st_q.vld;
    assign st_rd    = st_q.rd;
    assign st_wr    = st_q.wr;
    assign st_off   = st_q.off;
    assign st_idx   = st_q.idx;
    assign st_ent   = st_q.ent;
    assign stop_en  = st_q.stop_en;
    assign trace_en = st_q.trace_en;
endmodule

// File: rtl/emu_mapper.sv
module emu_mapper
    import emu_map_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_W     = 14,
    parameter int IDX_W     = 3,
    parameter int LINE_W    = 6,
    parameter int EMU_BLK_W = 6,
    parameter int RD_W      = 32,
    localparam int LINE_N   = 1 << (BLK_W - LINE_W),
    localparam int NWORD    = LINE_N / RD_W,
    localparam int WSEL_W   = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    output logic                       bus_wait,
    input  logic [1:0]                 host_op,
    input  logic [IDX_W-1:0]           host_idx,
    input  logic [ENTRY_W-1:0]         host_wdata,
    input  logic [IDX_W-1:0]           host_cov_blk,
    input  logic [WSEL_W-1:0]          host_cov_word,
    output logic [RD_W-1:0]            host_cov_rdata,
    output logic                       out_valid,
    output logic                       out_rd,
    output logic                       out_wr,
    output logic                       to_emu,
    output logic                       to_tgt,
    output logic [EMU_BLK_W+BLK_W-1:0] emu_addr,
    output logic [PHYS_W+BLK_W-1:0]    tgt_addr,
    output logic                       rom_viol,
    output logic                       wp_viol,
    output logic                       stop_req,
    output logic                       trace_trig
);
    localparam int LSEL_W = BLK_W - LINE_W;

    map_entry_t       look_ent;
    map_entry_t       st_ent;
    logic             st_vld, st_rd, st_wr, stop_en, trace_en;
    logic [BLK_W-1:0] st_off;
    logic [IDX_W-1:0] st_idx;
    logic             cov_set;

    emu_map_table #(.IDX_W(IDX_W)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_op == HOP_MAP),
        .wr_idx (host_idx),
        .wr_ent (map_entry_t'(host_wdata)),
        .rd_idx (bus_addr[BLK_W +: IDX_W]),
        .rd_ent (look_ent)
    );

    emu_access_stage #(.BLK_W(BLK_W), .IDX_W(IDX_W)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .in_off    (bus_addr[BLK_W-1:0]),
        .in_idx    (bus_addr[BLK_W +: IDX_W]),
        .in_ent    (look_ent),
        .ctl_we    (host_op == HOP_CTRL),
        .ctl_bits  (host_wdata[1:0]),
        .capture   (bus_wait),
        .st_vld    (st_vld),
        .st_rd     (st_rd),
        .st_wr     (st_wr),
        .st_off    (st_off),
        .st_idx    (st_idx),
        .st_ent    (st_ent),
        .stop_en   (stop_en),
        .trace_en  (trace_en)
    );

    assign cov_set = st_vld && st_ent.cov && (st_rd || st_wr);

    emu_cov_store #(.IDX_W(IDX_W), .LINE_N(LINE_N), .RD_W(RD_W)) cov_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cov_set),
        .set_blk  (st_idx),
        .set_line (st_off[BLK_W-1 -: LSEL_W]),
        .clr      (host_op == HOP_CLR),
        .rd_blk   (host_cov_blk),
        .rd_word  (host_cov_word),
        .rd_data  (host_cov_rdata)
    );

    assign out_valid  = st_vld;
    assign out_rd     = st_vld && st_rd;
    assign out_wr     = st_vld && st_wr;
    assign to_emu     = st_vld && st_ent.emu;
    assign to_tgt     = st_vld && !st_ent.emu;
    assign emu_addr   = {st_ent.phys[EMU_BLK_W-1:0], st_off};
    assign tgt_addr   = {st_ent.phys, st_off};
    assign rom_viol   = out_wr && st_ent.rom;
    assign wp_viol    = out_wr && st_ent.wprot;
    assign stop_req   = rom_viol && stop_en;
    assign trace_trig = rom_viol && trace_en;
endmodule

// File: rtl/emu_mapper_chk.sv
module emu_mapper_chk #(
    parameter int ADDR_W    = 32,
    parameter int BLK_W     = 14,
    parameter int EMU_BLK_W = 6,
    parameter int TGT_W     = 32,
    parameter int RD_W      = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wait,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [1:0]                 host_op,
    input logic [RD_W-1:0]            host_cov_rdata,
    input logic                       out_valid,
    input logic                       out_wr,
    input logic                       to_emu,
    input logic                       to_tgt,
    input logic [EMU_BLK_W+BLK_W-1:0] emu_addr,
    input logic [TGT_W-1:0]           tgt_addr,
    input logic                       rom_viol,
    input logic                       wp_viol,
    input logic                       stop_req,
    input logic                       trace_trig
);
    assert_wait_then_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> out_valid);

    assert_no_capture_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bus_wait);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |=> (emu_addr[BLK_W-1:0] == $past(bus_addr[BLK_W-1:0]))
                  && (tgt_addr[BLK_W-1:0] == $past(bus_addr[BLK_W-1:0])));

    assert_steer_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({to_emu, to_tgt}));

    assert_steer_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(to_emu || to_tgt));

    assert_rom_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_viol |-> (out_valid && out_wr));

    assert_stop_from_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || trace_trig) |-> rom_viol);

    assert_wp_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wp_viol |-> (out_valid && out_wr));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_op == 2'd3 && !out_valid) |=> (host_cov_rdata == '0));
endmodule

bind emu_mapper emu_mapper_chk #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .EMU_BLK_W(EMU_BLK_W),
    .TGT_W(emu_map_pkg::PHYS_W + BLK_W), .RD_W(RD_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wait(bus_wait), .bus_addr(bus_addr),
    .host_op(host_op), .host_cov_rdata(host_cov_rdata), .out_valid(out_valid),
    .out_wr(out_wr), .to_emu(to_emu), .to_tgt(to_tgt), .emu_addr(emu_addr),
    .tgt_addr(tgt_addr), .rom_viol(rom_viol), .wp_viol(wp_viol),
    .stop_req(stop_req), .trace_trig(trace_trig)
);

// File: tb/emu_mapper_tb_top.sv
module emu_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wait;
    logic [1:0]  host_op = 2'd0;
    logic [2:0]  host_idx = '0;
    logic [21:0] host_wdata = '0;
    logic [2:0]  host_cov_blk = '0;
    logic [2:0]  host_cov_word = '0;
    logic [31:0] host_cov_rdata;
    logic        out_valid, out_rd, out_wr, to_emu, to_tgt;
    logic [19:0] emu_addr;
    logic [31:0] tgt_addr;
    logic        rom_viol, wp_viol, stop_req, trace_trig;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic        s_emu, s_tgt, s_rom, s_wp, s_stop, s_trace;
    logic [31:0] s_eaddr, s_taddr;

    always #10 clk = ~clk;

    emu_mapper dut_i (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        emu;
        logic [31:0] oaddr;
        logic        rom;
        logic        wp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1234, 1'b0, 1'b0, 32'h0000_1234, 1'b0, 1'b0},
        '{32'h0000_4010, 1'b0, 1'b1, 32'h0001_4010, 1'b0, 1'b0},
        '{32'h0000_7FFC, 1'b0, 1'b1, 32'h0001_7FFC, 1'b0, 1'b0},
        '{32'h0000_8000, 1'b0, 1'b1, 32'h0001_8000, 1'b0, 1'b0},
        '{32'h0000_8004, 1'b1, 1'b1, 32'h0001_8004, 1'b1, 1'b0},
        '{32'h0000_8008, 1'b0, 1'b1, 32'h0001_8008, 1'b0, 1'b0},
        '{32'h0000_C100, 1'b1, 1'b0, 32'hAAF3_4100, 1'b0, 1'b1},
        '{32'h0000_C100, 1'b0, 1'b0, 32'hAAF3_4100, 1'b0, 1'b0},
        '{32'h0001_0020, 1'b1, 1'b1, 32'h0001_C020, 1'b0, 1'b1},
        '{32'hFFF8_4010, 1'b0, 1'b1, 32'h0001_4010, 1'b0, 1'b0},
        '{32'h0001_C000, 1'b1, 1'b0, 32'h0001_C000, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic do_access(input logic [31:0] a, input logic w);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_wr = w; bus_rd = !w;
        #1 check("R1 wait in capture cycle", 32'(bus_wait), 32'd1);
        @(negedge clk);
        check("R1 out_valid in result cycle", 32'(out_valid), 32'd1);
        check("R1 wait low in result cycle", 32'(bus_wait), 32'd0);
        s_emu = to_emu; s_tgt = to_tgt; s_rom = rom_viol; s_wp = wp_viol;
        s_stop = stop_req; s_trace = trace_trig;
        s_eaddr = {12'd0, emu_addr}; s_taddr = tgt_addr;
        bus_valid = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic host_cmd(input logic [1:0] op, input logic [2:0] idx, input logic [21:0] d);
        @(negedge clk);
        host_op = op; host_idx = idx; host_wdata = d;
        #1;
        check("R10 no out_valid on host op", 32'(out_valid), 32'd0);
        check("R10 no violation on host op", 32'(rom_viol | wp_viol), 32'd0);
        @(negedge clk);
        host_op = 2'd0;
    endtask

    function automatic logic [31:0] cov_rd(input logic [2:0] blk, input logic [2:0] word);
        return 32'(0) | {29'd0, blk} | 32'(word); // placeholder-free helper not used
    endfunction

    task automatic read_cov(input logic [2:0] blk, input logic [2:0] word, output logic [31:0] v);
        host_cov_blk = blk; host_cov_word = word;
        #1 v = host_cov_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid low after reset", 32'(out_valid), 32'd0);
        check("R9 wait low when idle", 32'(bus_wait), 32'd0);
        read_cov(3'd1, 3'd0, v);
        check("R9 coverage clear after reset", v, 32'd0);
        rst_n = 1'b1;
        do_access(32'h0000_4010, 1'b0);
        check("R9 identity entry goes to target", 32'(s_tgt), 32'd1);
        check("R9 identity target address", s_taddr, 32'h0000_4010);
        do_access(32'h0000_8004, 1'b1);
        check("R9 no ROM attribute after reset", 32'(s_rom | s_wp), 32'd0);
        check("R9 stop/trace off after reset", 32'(s_stop | s_trace), 32'd0);

        host_cmd(2'd1, 3'd1, 22'h24_0005);
        host_cmd(2'd1, 3'd2, 22'h0C_0006);
        host_cmd(2'd1, 3'd3, 22'h12_ABCD);
        host_cmd(2'd1, 3'd4, 22'h14_0007);

        for (int i = 0; i < NVEC; i++) begin
            do_access(VECS[i].addr, VECS[i].wr);
            check($sformatf("R3 steer emu v%0d", i), 32'(s_emu), 32'(VECS[i].emu));
            check($sformatf("R3 steer tgt v%0d", i), 32'(s_tgt), 32'(!VECS[i].emu));
            check($sformatf("R2 address v%0d", i),
                  VECS[i].emu ? s_eaddr : s_taddr, VECS[i].oaddr);
            check($sformatf("R4 rom_viol v%0d", i), 32'(s_rom), 32'(VECS[i].rom));
            check($sformatf("R6 wp_viol v%0d", i), 32'(s_wp), 32'(VECS[i].wp));
            check($sformatf("R5 disabled actions v%0d", i), 32'(s_stop | s_trace), 32'd0);
        end

        // R7: coverage readback
        @(negedge clk);
        read_cov(3'd1, 3'd0, v);
        check("R7 line 0 of entry 1", v, 32'h0000_0001);
        read_cov(3'd1, 3'd7, v);
        check("R7 line 255 of entry 1", v, 32'h8000_0000);
        read_cov(3'd2, 3'd0, v);
        check("R7 no coverage without attribute", v, 32'd0);

        // R8: clear concurrent with a set
        do_access(32'h0000_4080, 1'b1);
        host_op = 2'd3;
        @(negedge clk);
        host_op = 2'd0;
        read_cov(3'd1, 3'd0, v);
        check("R8 concurrent set survives clear", v, 32'h0000_0004);
        read_cov(3'd1, 3'd7, v);
        check("R8 old bits cleared", v, 32'd0);
        host_cmd(2'd3, 3'd0, 22'd0);
        read_cov(3'd1, 3'd0, v);
        check("R8 plain clear", v, 32'd0);

        // R5: action enables
        host_cmd(2'd2, 3'd0, 22'd1);
        do_access(32'h0000_8004, 1'b1);
        check("R5 stop only: stop", 32'(s_stop), 32'd1);
        check("R5 stop only: trace", 32'(s_trace), 32'd0);
        host_cmd(2'd2, 3'd0, 22'd2);
        do_access(32'h0000_8004, 1'b1);
        check("R5 trace only: stop", 32'(s_stop), 32'd0);
        check("R5 trace only: trace", 32'(s_trace), 32'd1);
        host_cmd(2'd2, 3'd0, 22'd3);
        do_access(32'h0000_8004, 1'b1);
        check("R5 both enabled", {30'd0, s_stop, s_trace}, 32'd3);
        do_access(32'h0000_8008, 1'b0);
        check("R5 no action on ROM read", 32'(s_stop | s_trace), 32'd0);

        // R10: ROM entry rewritten from host
        host_cmd(2'd1, 3'd2, 22'h04_0006);
        do_access(32'h0000_8004, 1'b1);
        check("R10 rewritten entry no ROM", 32'(s_rom), 32'd0);
        check("R10 rewritten entry still emu", s_eaddr, 32'h0001_8004);

        @(negedge clk);
        check("R1 idle after access", 32'(out_valid), 32'd0);
        finish_run();
    end
endmodule